// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit with Signed Overflow Flag

This block is the combinational execute-stage ALU of a small load-store integer core. It takes two operands and a 4-bit operation code. In the same cycle it returns a result word, a zero flag and an overflow flag. One ripple-carry adder serves both addition and subtraction. For a subtraction it inverts operand B and forces the carry-in to 1. The two set-on-less-than compares reuse the same subtraction.

The surrounding pipeline is responsible for extending immediates, for multiply and divide, and for turning an overflow into an exception. The zero flag is meaningful for every operation, so equality branches can use it directly. The default width is 32 bits, and the width is a parameter.

Top module: `alu_core`

## Requirements
- R1: Code 0010 (signed add) and code 0011 (unsigned add) return (A + B) modulo 2^WIDTH.
- R2: Code 0110 (signed subtract) and code 0111 (unsigned subtract) return (A - B) modulo 2^WIDTH.
- R3: For code 0010, overflow is 1 exactly when the true two's-complement sum lies outside the signed range. It is never 1 when A and B have opposite signs.
- R4: For code 0110, overflow is 1 exactly when the true two's-complement difference lies outside the signed range. It is never 1 when A and B have the same sign.
- R5: Overflow stays 0 for every code other than 0010 and 0110, including the unsigned add and unsigned subtract.
- R6: Code 0000 returns A AND B. Code 0001 returns A OR B. Code 0100 returns A XOR B. Code 1100 returns NOT(A OR B).
- R7: Code 1000 returns 1 when A < B as signed numbers, and 0 otherwise. The value is zero-extended to the full width.
- R8: Code 1001 returns 1 when A < B as unsigned numbers, and 0 otherwise. The value is zero-extended to the full width.
- R9: The zero flag is 1 exactly when every result bit is 0, for every code.
- R10: Every code not listed above returns a result of 0 with overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opSel | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| zeroFlag | output | 1 | 1 when result is all zeros |
| overflow | output | 1 | Signed overflow of signed add or subtract |

## Verification
The bench builds one instance with WIDTH=4. At that width every operand pair under all sixteen codes can be swept: 4096 combinations. The sweep reaches every carry chain pattern, every signed overflow corner and every unused code. A second instance is built with the default WIDTH=32. It is driven with directed extremes: largest positive plus one, most negative minus one, unsigned wrap to zero, and compares of the most negative value. These show that the carry reaches the top bit of the full-width chain.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_ADDU = 4'b0011,
    OP_XOR  = 4'b0100,
    OP_SUB  = 4'b0110,
    OP_SUBU = 4'b0111,
    OP_SLT  = 4'b1000,
    OP_SLTU = 4'b1001,
    OP_NOR  = 4'b1100
  } aluOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic invertB;   // complement B and force carry-in high
    logic useSum;
    logic useAnd;
    logic useOr;
    logic useXor;
    logic useNor;
    logic useSlt;
    logic useSltu;
    logic ovfEn;     // report signed overflow
  } aluStrobes_t;

endpackage

// File: rtl/alu_fa.sv
module alu_fa (
  input  logic x,
  input  logic y,
  input  logic cIn,
  output logic s,
  output logic cOut
);
  assign s    = x ^ y ^ cIn;
  assign cOut = (x & y) | (x & cIn) | (y & cIn);
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]  opSel,
  output aluStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    case (opSel)
      OP_AND:  strobes.useAnd = 1'b1;
      OP_OR:   strobes.useOr  = 1'b1;
      OP_XOR:  strobes.useXor = 1'b1;
      OP_NOR:  strobes.useNor = 1'b1;
      OP_ADD: begin
        strobes.useSum = 1'b1;
        strobes.ovfEn  = 1'b1;
      end
      OP_ADDU: strobes.useSum = 1'b1;
      OP_SUB: begin
        strobes.useSum  = 1'b1;
        strobes.invertB = 1'b1;
        strobes.ovfEn   = 1'b1;
      end
      OP_SUBU: begin
        strobes.useSum  = 1'b1;
        strobes.invertB = 1'b1;
      end
      OP_SLT: begin
        strobes.useSlt  = 1'b1;
        strobes.invertB = 1'b1;
      end
      OP_SLTU: begin
        strobes.useSltu = 1'b1;
        strobes.invertB = 1'b1;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sum;
  logic [WIDTH:0]   carry;
  logic             ovfRaw;
  logic             sltBit;
  logic             sltuBit;

  assign bEff     = opB ^ {WIDTH{strobes.invertB}};
  assign carry[0] = strobes.invertB;

  for (genvar i = 0; i < WIDTH; i++) begin : g_ripple
    alu_fa fa_i (
      .x   (opA[i]),
      .y   (bEff[i]),
      .cIn (carry[i]),
      .s   (sum[i]),
      .cOut(carry[i+1])
    );
  end

  assign ovfRaw  = carry[MSB] ^ carry[WIDTH];
  assign sltBit  = sum[MSB] ^ ovfRaw;
  assign sltuBit = ~carry[WIDTH];

  always_comb begin
    result = '0;
    if (strobes.useSum)  result = result | sum;
    if (strobes.useAnd)  result = result | (opA & opB);
    if (strobes.useOr)   result = result | (opA | opB);
    if (strobes.useXor)  result = result | (opA ^ opB);
    if (strobes.useNor)  result = result | ~(opA | opB);
    if (strobes.useSlt)  result = result | {{(WIDTH-1){1'b0}}, sltBit};
    if (strobes.useSltu) result = result | {{(WIDTH-1){1'b0}}, sltuBit};
  end

  assign zeroFlag = ~|result;
  assign overflow = strobes.ovfEn & ovfRaw;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             overflow
);
  aluStrobes_t strobes;

  alu_ctrl ctrl_i (
    .opSel  (opSel),
    .strobes(strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .zeroFlag(zeroFlag),
    .overflow(overflow)
  );
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       opSel,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             overflow
);
  localparam int MSB = WIDTH - 1;

  logic known;
  assign known = !$isunknown({opA, opB, opSel, result, zeroFlag, overflow});

  always_comb begin
    if (known) begin
      // R5: overflow only for signed add and signed subtract
      if (opSel != 4'b0010 && opSel != 4'b0110)
        p_no_overflow_r5: assert (!overflow);
      // R3: opposite signs never overflow on add
      if (opSel == 4'b0010 && opA[MSB] != opB[MSB])
        p_add_mixed_sign_r3: assert (!overflow);
      // R3: a reported add overflow flips the sign against the operands
      if (opSel == 4'b0010 && overflow)
        p_add_ovf_sign_r3: assert (result[MSB] != opA[MSB]);
      // R4: same signs never overflow on subtract
      if (opSel == 4'b0110 && opA[MSB] == opB[MSB])
        p_sub_same_sign_r4: assert (!overflow);
      // R7 and R8: compare results are zero-extended
      if (opSel == 4'b1000 || opSel == 4'b1001)
        p_slt_extend_r7: assert (result[MSB:1] == '0);
      // R10: unused codes return zero
      if (!(opSel inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100,
                          4'b0110, 4'b0111, 4'b1000, 4'b1001, 4'b1100}))
        p_unused_zero_r10: assert (result == '0 && zeroFlag);
    end
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) chk_i (
  .opA     (opA),
  .opB     (opB),
  .opSel   (opSel),
  .result  (result),
  .zeroFlag(zeroFlag),
  .overflow(overflow)
);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Small instance, swept exhaustively
  logic [3:0] nA, nB, nSel, nRes;
  logic       nZero, nOvf;

  alu_core #(.WIDTH(4)) dut_i (
    .opA(nA), .opB(nB), .opSel(nSel),
    .result(nRes), .zeroFlag(nZero), .overflow(nOvf)
  );

  // Full-width instance, directed corners
  logic [31:0] wA, wB, wRes;
  logic [3:0]  wSel;
  logic        wZero, wOvf;

  alu_core #(.WIDTH(32)) dutWide_i (
    .opA(wA), .opB(wB), .opSel(wSel),
    .result(wRes), .zeroFlag(wZero), .overflow(wOvf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%h a=%h b=%h actual=%h expected=%h", tag, nSel, nA, nB, act, exp);
    end
  endtask

  task automatic wideChk(input string tag, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] expRes, input logic expOvf);
    @(posedge clk);
    wSel = op; wA = a; wB = b;
    @(negedge clk);
    checks++;
    if (wRes !== expRes || wOvf !== expOvf || wZero !== (expRes == 0)) begin
      errors++;
      $display("FAIL %s wide op=%h actual=%h/%b/%b expected=%h/%b/%b", tag, op,
               wRes, wOvf, wZero, expRes, expOvf, (expRes == 0));
    end
  endtask

  initial begin
    nA = '0; nB = '0; nSel = 4'b0000;
    wA = '0; wB = '0; wSel = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: idle AND of zeros gives zero result with zero flag
    chk("R9 initial result", {28'd0, nRes}, 32'd0);
    chk("R9 initial zero", {31'd0, nZero}, 32'd1);
    chk("R5 initial ovf", {31'd0, nOvf}, 32'd0);

    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int sa, sb, full, er;
          int eo;
          string tag;
          @(posedge clk);
          nSel = op[3:0]; nA = a[3:0]; nB = b[3:0];
          @(negedge clk);
          sa = (a >= 8) ? a - 16 : a;
          sb = (b >= 8) ? b - 16 : b;
          eo = 0;
          case (op)
            0:  begin er = a & b;           tag = "R6 and"; end
            1:  begin er = a | b;           tag = "R6 or"; end
            4:  begin er = a ^ b;           tag = "R6 xor"; end
            12: begin er = (~(a | b)) & 15; tag = "R6 nor"; end
            2:  begin er = (a + b) & 15; full = sa + sb;
                      eo = (full > 7 || full < -8) ? 1 : 0; tag = "R1 add"; end
            3:  begin er = (a + b) & 15;    tag = "R1 addu"; end
            6:  begin er = (a - b) & 15; full = sa - sb;
                      eo = (full > 7 || full < -8) ? 1 : 0; tag = "R2 sub"; end
            7:  begin er = (a - b) & 15;    tag = "R2 subu"; end
            8:  begin er = (sa < sb) ? 1 : 0; tag = "R7 slt"; end
            9:  begin er = (a < b) ? 1 : 0;   tag = "R8 sltu"; end
            default: begin er = 0;          tag = "R10 unused"; end
          endcase
          chk(tag, {28'd0, nRes}, er);
          if (op == 2)      chk("R3 ovf", {31'd0, nOvf}, eo);
          else if (op == 6) chk("R4 ovf", {31'd0, nOvf}, eo);
          else              chk("R5 ovf", {31'd0, nOvf}, 32'd0);
          chk("R9 zero", {31'd0, nZero}, (er == 0) ? 1 : 0);
        end
      end
    end

    wideChk("R3 max+1",     4'b0010, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1'b1);
    wideChk("R3 mixed",     4'b0010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFE, 1'b0);
    wideChk("R4 min-1",     4'b0110, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 1'b1);
    wideChk("R4 same sign", 4'b0110, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b0);
    wideChk("R1 addu wrap", 4'b0011, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b0);
    wideChk("R2 subu wrap", 4'b0111, 32'h0, 32'h1, 32'hFFFF_FFFF, 1'b0);
    wideChk("R7 slt min",   4'b1000, 32'h8000_0000, 32'h1, 32'h1, 1'b0);
    wideChk("R8 sltu min",  4'b1001, 32'h8000_0000, 32'h1, 32'h0, 1'b0);
    wideChk("R6 nor",       4'b1100, 32'hF0F0_0000, 32'h0000_0F0F, 32'h0F0F_F0F0, 1'b0);
    wideChk("R10 unused",   4'b1111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule